// File: doc/BRIEF.md
# Low-Speed USB Bitstream Receiver

This block recovers packet bytes from a low-speed USB differential pair. It runs at eight system clocks per bit, so a 12 MHz clock gives the 1.5 Mbit/s line rate. While the bus idles in the J state it waits for the first J-to-K transition. Through the synchronisation pattern it restarts its bit-phase counter on every line transition, which places the sampling point in the middle of each bit. Once it has sampled two K bits in a row, it treats the following bits as packet payload.

In the payload phase each sample is NRZI-decoded against the previous bit. A bit that follows six decoded ones is discarded as a stuffed bit. Bits are packed least significant first into bytes, and each byte goes into an eleven-entry packet buffer. A sampled SE0 ends the packet with a one-cycle done pulse and the received byte count. The buffer can then be read through a plain address/data port. An SE0 held much longer than a byte time is reported as a bus reset. PID decoding, CRC checking and transmission belong to other blocks.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset packet_done_o, error_o, overflow_o and bus_reset_o are 0 and byte_count_o is 0.
- R2: A packet is entered on a J-to-K transition from idle (J = dm high/dp low, K = dp high/dm low). Reception of data starts on the bit after two consecutively sampled K bits, and the sync pattern itself is never stored, so buffer address 0 holds the first byte after it.
- R3: A data bit decodes as 0 when the line level differs from the previous bit and as 1 when it is unchanged. Bytes are assembled least significant bit first and stored at addresses 0, 1, 2 … in arrival order.
- R4: The bit that follows six consecutive decoded 1s, counting the final 1 of the sync pattern, is removed and never enters a data byte, including when the run spans a byte boundary.
- R5: If the bit following six 1s is itself a 1, the packet ends at once with packet_done_o, error_o = 1, overflow_o = 0 and byte_count_o equal to the bytes completed before it. The receiver then ignores the line until the next SE0.
- R6: A sampled SE0 (both lines low) during data ends the packet with packet_done_o high for exactly one cycle. byte_count_o then equals the complete bytes received, and error_o = overflow_o = 0 for a clean packet. These outputs hold until the next packet end.
- R7: If more than 11 bytes arrive, the first 11 are kept, and the packet end reports byte_count_o = 11, overflow_o = 1 and error_o = 1.
- R8: bus_reset_o rises once SE0 has lasted RESET_CLKS clocks and falls within a few clocks of SE0 ending. A normal two-bit end-of-packet never raises it.
- R9: After a packet end the receiver waits for J before re-arming, so back-to-back packets separated by a single idle bit are each received and reported.
- R10: The sampling phase is recovered per packet, so packets are received correctly whatever the clock offset of their first transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLKS_PER_BIT clocks per bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| rd_addr_i | input | AW | Packet buffer read address |
| rd_data_o | output | 8 | Packet buffer byte at rd_addr_i |
| packet_done_o | output | 1 | One-cycle pulse at packet end |
| byte_count_o | output | CW | Bytes stored in the last packet |
| error_o | output | 1 | Last packet aborted or overflowed |
| overflow_o | output | 1 | Last packet exceeded the buffer |
| bus_reset_o | output | 1 | Long SE0 present on the bus |

## Verification
The bench drives packets whose first edge falls at every clock offset within a bit. A receiver that only aligned on the first edge, or that sampled off-centre, would decode shifted bytes. Long runs of ones are placed so that stuffed bits land at byte boundaries and directly after the sync pattern. A destuffer that restarted its count per byte or ignored the sync's last 1 would store the stuffed bit or reject a legal packet. Overflowing, stuff-violating and back-to-back packets check that the count saturates at 11, that an abort stays silent until the next SE0, and that a one-bit gap re-arms the receiver. A long SE0 is compared against the two-bit end-of-packet to catch a reset detector with the wrong threshold.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_DATA, ST_WAIT_SE0, ST_WAIT_J
  } rx_state_e;

  typedef struct packed {
    logic lvl;   // dm level, 1 = J
    logic is_j;
    logic is_k;
    logic is_se0;
  } line_t;
endpackage

// File: rtl/usb_ls_rx_line.sv
module usb_ls_rx_line #(
  parameter int RESET_CLKS = 120
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dp_i,
  input  logic                  dm_i,
  output usb_ls_rx_pkg::line_t  line_o,
  output logic                  bus_reset_o
);
  localparam int TW = $clog2(RESET_CLKS + 1);

  logic [1:0] dp_q, dm_q;
  logic [TW-1:0] se0_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_q <= 2'b00;
      dm_q <= 2'b11;
    end else begin
      dp_q <= {dp_q[0], dp_i};
      dm_q <= {dm_q[0], dm_i};
    end
  end

  always_comb begin
    line_o.lvl    = dm_q[1];
    line_o.is_j   = dm_q[1] & ~dp_q[1];
    line_o.is_k   = dp_q[1] & ~dm_q[1];
    line_o.is_se0 = ~dp_q[1] & ~dm_q[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se0_cnt     <= '0;
      bus_reset_o <= 1'b0;
    end else begin
      if (!line_o.is_se0)                    se0_cnt <= '0;
      else if (se0_cnt != TW'(RESET_CLKS))   se0_cnt <= se0_cnt + 1'b1;
      bus_reset_o <= line_o.is_se0 && (se0_cnt >= TW'(RESET_CLKS - 1));
    end
  end
endmodule

// File: rtl/usb_ls_rx_core.sv
module usb_ls_rx_core #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DEPTH        = 11,
  parameter int STUFF_LEN    = 6,
  localparam int PW = $clog2(CLKS_PER_BIT),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  usb_ls_rx_pkg::line_t  line_i,
  output logic                  wr_en_o,
  output logic [CW-1:0]         wr_addr_o,
  output logic [7:0]            wr_data_o,
  output logic                  packet_done_o,
  output logic [CW-1:0]         byte_count_o,
  output logic                  error_o,
  output logic                  overflow_o
);
  import usb_ls_rx_pkg::*;
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int OW   = $clog2(STUFF_LEN + 1);

  rx_state_e     state;
  logic [PW-1:0] phase;
  logic          last_lvl, prev_lvl, k_seen, ovf;
  logic [OW-1:0] ones;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;
  logic [CW-1:0] cnt;

  logic edge_seen, sample, dbit, stuff_slot, byte_done;

  always_comb begin
    edge_seen  = line_i.lvl != last_lvl;
    sample     = phase == PW'(HALF);
    dbit       = line_i.lvl == prev_lvl;
    stuff_slot = ones == OW'(STUFF_LEN);
    byte_done  = (state == ST_DATA) && sample && !line_i.is_se0 &&
                 !stuff_slot && (bit_idx == 3'd7);
    wr_en_o    = byte_done && (cnt != CW'(DEPTH));
    wr_addr_o  = cnt;
    wr_data_o  = {dbit, shreg[7:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; phase <= '0; last_lvl <= 1'b1; prev_lvl <= 1'b1;
      k_seen <= 1'b0; ovf <= 1'b0; ones <= '0; bit_idx <= '0; shreg <= '0;
      cnt <= '0; packet_done_o <= 1'b0; byte_count_o <= '0;
      error_o <= 1'b0; overflow_o <= 1'b0;
    end else begin
      last_lvl      <= line_i.lvl;
      packet_done_o <= 1'b0;
      // realign phase on every transition until data starts
      if (state inside {ST_IDLE, ST_SYNC} && edge_seen)  phase <= '0;
      else if (phase == PW'(CLKS_PER_BIT - 1))          phase <= '0;
      else                                              phase <= phase + 1'b1;

      unique case (state)
        ST_IDLE: begin
          k_seen <= 1'b0;
          if (line_i.is_k && last_lvl) state <= ST_SYNC;
        end
        ST_SYNC: if (sample) begin
          if (line_i.is_se0) state <= ST_WAIT_J;
          else if (line_i.is_k) begin
            k_seen <= 1'b1;
            if (k_seen) begin
              state <= ST_DATA; prev_lvl <= 1'b0; ones <= OW'(1);
              bit_idx <= '0; cnt <= '0; ovf <= 1'b0;
            end
          end else k_seen <= 1'b0;
        end
        ST_DATA: if (sample) begin
          if (line_i.is_se0) begin
            packet_done_o <= 1'b1; byte_count_o <= cnt;
            error_o <= ovf; overflow_o <= ovf; state <= ST_WAIT_J;
          end else begin
            prev_lvl <= line_i.lvl;
            if (stuff_slot) begin
              ones <= '0;
              if (dbit) begin
                packet_done_o <= 1'b1; byte_count_o <= cnt;
                error_o <= 1'b1; overflow_o <= ovf; state <= ST_WAIT_SE0;
              end
            end else begin
              ones    <= dbit ? ones + 1'b1 : '0;
              shreg   <= {dbit, shreg[7:1]};
              bit_idx <= bit_idx + 1'b1;
              if (byte_done) begin
                if (cnt == CW'(DEPTH)) ovf <= 1'b1;
                else                   cnt <= cnt + 1'b1;
              end
            end
          end
        end
        ST_WAIT_SE0: if (line_i.is_se0) state <= ST_WAIT_J;
        ST_WAIT_J:   if (line_i.is_j)   state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_rx_buf.sv
module usb_ls_rx_buf #(
  parameter int DEPTH = 11,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  entry[g] <= '0;
      else if (wr_en_i && wr_addr_i == CW'(g))      entry[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = entry[i];
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DEPTH        = 11,
  parameter int STUFF_LEN    = 6,
  parameter int RESET_CLKS   = 120,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dp_i,
  input  logic          dm_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          packet_done_o,
  output logic [CW-1:0] byte_count_o,
  output logic          error_o,
  output logic          overflow_o,
  output logic          bus_reset_o
);
  usb_ls_rx_pkg::line_t line;
  logic          wr_en;
  logic [CW-1:0] wr_addr;
  logic [7:0]    wr_data;

  usb_ls_rx_line #(.RESET_CLKS(RESET_CLKS)) u_line (
    .clk_i, .rst_ni, .dp_i, .dm_i, .line_o(line), .bus_reset_o
  );

  usb_ls_rx_core #(.CLKS_PER_BIT(CLKS_PER_BIT), .DEPTH(DEPTH), .STUFF_LEN(STUFF_LEN)) u_core (
    .clk_i, .rst_ni, .line_i(line), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .packet_done_o, .byte_count_o, .error_o, .overflow_o
  );

  usb_ls_rx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i, .rd_data_o
  );
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int DEPTH = 11,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dp_i,
  input logic          dm_i,
  input logic          packet_done_o,
  input logic [CW-1:0] byte_count_o,
  input logic          error_o,
  input logic          overflow_o,
  input logic          bus_reset_o
);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    packet_done_o |=> !packet_done_o);
  // R6
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !packet_done_o |-> $stable(byte_count_o));
  // R7
  overflow_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> error_o);
  // R7
  count_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_count_o <= CW'(DEPTH));
  // R8
  reset_se0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |-> $past(!dp_i && !dm_i, 3));
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .dp_i, .dm_i, .packet_done_o, .byte_count_o,
  .error_o, .overflow_o, .bus_reset_o
);

// File: tb/usb_ls_rx_bench.sv
module usb_ls_rx_bench;
  localparam int DEPTH = 11;
  localparam int CPB   = 8;
  localparam int RCLK  = 120;

  logic clk = 1'b0, rst_ni = 1'b0, dp = 1'b0, dm = 1'b1;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic packet_done, error, overflow, bus_reset;
  logic [3:0] byte_count;

  int compared = 0, mismatched = 0;
  bit pending = 0, prev_done = 0, saw_reset = 0, finished = 0;

  always #2 clk = ~clk;

  usb_ls_rx u_usb_ls_rx (
    .clk_i(clk), .rst_ni, .dp_i(dp), .dm_i(dm), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .packet_done_o(packet_done), .byte_count_o(byte_count),
    .error_o(error), .overflow_o(overflow), .bus_reset_o(bus_reset)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-clock comparison of the done pulse against the model's pending flag
  always @(negedge clk) if (rst_ni) begin
    if (packet_done) begin
      chk("R6 pulse only when a packet is pending", int'(pending), 1);
      pending = 0;
    end
    if (packet_done && prev_done) chk("R6 single-cycle pulse", 2, 1);
    prev_done = packet_done;
    if (bus_reset) saw_reset = 1;
  end

  task automatic line_bit(input bit lvl);
    dm = lvl; dp = ~lvl;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic idle_clks(input int n);
    dm = 1'b1; dp = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // returns expected count; encoder is independent of the RTL
  task automatic send_pkt(input logic [7:0] data[$], input bit stuff_ok, output int viol_byte);
    bit bits[$];
    bit lvl = 1'b1;
    int ones = 0;
    viol_byte = -1;
    for (int i = 0; i < 8; i++) bits.push_back(i == 7);
    foreach (data[b]) for (int i = 0; i < 8; i++) bits.push_back(data[b][i]);
    pending = 1;
    foreach (bits[i]) begin
      if (!stuff_ok && ones == 6 && bits[i] && viol_byte < 0) viol_byte = (i - 8) / 8;
      if (!bits[i]) lvl = ~lvl;
      ones = bits[i] ? ones + 1 : 0;
      line_bit(lvl);
      if (stuff_ok && ones == 6) begin
        lvl = ~lvl; ones = 0; line_bit(lvl);
      end
    end
    dm = 1'b0; dp = 1'b0;
    repeat (2 * CPB) @(negedge clk);
    idle_clks(CPB);
  endtask

  task automatic run_pkt(input string req, input logic [7:0] data[$], input int gap);
    int v, n, exp_cnt;
    idle_clks(gap);
    send_pkt(data, 1'b1, v);
    repeat (4) @(negedge clk);
    n = data.size();
    exp_cnt = n > DEPTH ? DEPTH : n;
    chk({req, " done seen"}, int'(pending), 0);
    chk({req, " byte count"}, int'(byte_count), exp_cnt);
    chk({req, " overflow"}, int'(overflow), int'(n > DEPTH));
    chk({req, " error"}, int'(error), int'(n > DEPTH));
    for (int i = 0; i < exp_cnt; i++) begin
      rd_addr = 4'(i); #1;
      chk({req, " buffer byte"}, int'(rd_data), int'(data[i]));
    end
  endtask

  initial begin
    logic [7:0] q[$];
    int v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 packet_done", int'(packet_done), 0);
    chk("R1 byte_count", int'(byte_count), 0);
    chk("R1 error", int'(error), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 bus_reset", int'(bus_reset), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3: plain packet; R10: vary first-edge offset over a whole bit
    for (int off = 0; off < CPB; off++) begin
      q = '{8'h69, 8'(8'h3C + off), 8'hA1};
      run_pkt("R2 R3 R10", q, 20 + off);
    end
    // R4: stuffing after sync's final 1, across byte boundary, long runs
    q = '{8'h3F, 8'hC0, 8'h0F, 8'hFF, 8'hFF, 8'h7E};
    run_pkt("R4 stuff", q, 13);
    q = '{8'hFF};
    run_pkt("R4 stuff at start", q, 9);
    // R7: exactly full, then overflow
    q = '{8'h4B, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA};
    run_pkt("R7 full", q, 11);
    q = '{8'hC3, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C};
    run_pkt("R7 overflow", q, 17);
    // R5: seventh 1 without stuffing
    idle_clks(15);
    q = '{8'hA5, 8'hFF, 8'h12};
    send_pkt(q, 1'b0, v);
    repeat (4) @(negedge clk);
    chk("R5 done seen", int'(pending), 0);
    chk("R5 error", int'(error), 1);
    chk("R5 overflow", int'(overflow), 0);
    chk("R5 count", int'(byte_count), v);
    rd_addr = 4'd0; #1;
    chk("R5 byte before abort", int'(rd_data), 8'hA5);
    // R9: back-to-back with single idle bit
    q = '{8'hE1, 8'h5A};
    run_pkt("R9 first", q, 4);
    q = '{8'h87, 8'hB2, 8'h0D};
    run_pkt("R9 second", q, 0);
    // R8: normal EOPs never raised reset; long SE0 does
    chk("R8 no reset from EOP", int'(saw_reset), 0);
    dm = 1'b0; dp = 1'b0;
    repeat (RCLK - 10) @(negedge clk);
    chk("R8 not yet reset", int'(bus_reset), 0);
    repeat (20) @(negedge clk);
    chk("R8 reset asserted", int'(bus_reset), 1);
    idle_clks(6);
    chk("R8 reset released", int'(bus_reset), 0);
    idle_clks(20);
    q = '{8'hD2, 8'h44};
    run_pkt("R9 after reset", q, 3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule